// File: doc/BRIEF.md
# Three-Wire Configuration Register Receiver

This block sits on the transceiver side of a three-wire programming bus made of a serial clock, a serial data line and an active-low frame enable. While the enable is low, each rising edge of the bus clock shifts one data bit into a shift register. The most significant bit arrives first. When the enable returns high, the collected word is checked and decoded. If the word is valid, it becomes the new control setting for the synthesizer divider, the reference select, the transmit deviation scale, the external power-amplifier ramp level and the receive clock-recovery enable.

All three bus lines are asynchronous to the system clock. They pass through synchronizer flops, and edges are found in the system clock domain. Words may be 16 bits long, or 25 bits long when clock recovery is requested. The number of clocks in a frame is not counted: only the trailing bits held in the register matter. Each accepted word produces a one-cycle pulse. The decoded fields and a mode code stay valid until the next accepted word arrives.

Top module: `cfg3w_slave`

## Requirements
- R1: After reset the outputs are: mode 0 (unconfigured), cr_en 0, power level 0, deviation code 4 (100 %), reference select 0, main-counter code 0 (divisor 86), swallow 0, divider total 2752, and no pulse.
- R2: A bit is captured on each rising bus clock edge while enable is low, MSB first. A word with D15:D14 = 01 and D8 = 1 is a transmit word. It sets mode 1 and loads: power level from D13:D12, deviation code from D11:D9, reference select from D7, main-counter code from D6:D5 and swallow value from D4:D0.
- R3: While enable is still low, every decoded output keeps its previous value. A new word takes effect only after enable rises.
- R4: The bit count is not checked. Bits beyond the last 25 drop out of the register. Extra leading bits in front of a 16-bit word do not alter its decoding, and a frame with zero clocks decodes an all-zero word.
- R5: Bus clock edges while enable is high shift nothing and latch nothing.
- R6: A word with D15:D14 = 01 and D8 = 0 is a receive word. It sets mode 2 and loads reference select, main-counter code and swallow value. Power level and deviation code keep their previous values.
- R7: If D24:D16 equals 1_0100_0000 and D15:D14 = 00, the word sets mode 3 and cr_en = 1, and loads reference, main-counter and swallow fields. The same prefix with any other D15:D14 value makes the word invalid.
- R8: If the 9-bit prefix does not match exactly, only D15:D0 are decoded, whatever the upper bits hold.
- R9: An invalid word is ignored: no pulse, and no output changes. A word is invalid if it matches none of the forms above, for example D15:D14 = 10.
- R10: cfg_valid_o is high for exactly one system clock cycle per accepted word, in the cycle the new values first appear.
- R11: Derived outputs follow the codes: deviation percent = 60 + 10 × code, main divisor = 86 + code, divider total = 32 × main divisor + swallow.
- R12: The shift register clears when a frame starts. A 16-bit word sent after a 25-bit clock-recovery word therefore decodes as a 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock (asynchronous) |
| bus_dat_i | input | 1 | Serial bus data (asynchronous) |
| bus_en_ni | input | 1 | Active-low frame enable (asynchronous) |
| cfg_valid_o | output | 1 | One-cycle pulse when a word is accepted |
| mode_o | output | 2 | 0 unconfigured, 1 transmit, 2 receive, 3 receive with clock recovery |
| cr_en_o | output | 1 | Clock recovery enabled |
| pa_lvl_o | output | 2 | External PA ramp level code |
| dev_code_o | output | 3 | Deviation scale code |
| dev_pct_o | output | 8 | Deviation scale in percent |
| ref_sel_o | output | 1 | Reference clock select |
| mc_code_o | output | 2 | Main-counter code |
| main_div_o | output | 7 | Main-counter divisor |
| swallow_o | output | 5 | Swallow-counter value |
| div_n_o | output | 12 | Total synthesizer divide value |

## Verification
The assertions assume that each bus phase stays stable for at least three system clock cycles. Under that assumption the synchronized data is settled at every detected clock rise, and an enable edge never coincides with a detected clock rise. In particular, the shift-register property assumes that a clear and a shift are never requested in the same cycle. The stimulus holds every data, clock and enable phase for four system cycles, and it leaves at least six cycles between an enable edge and the nearest bus clock edge. The bench checks the hold behaviour in the middle of each frame, before enable rises.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int unsigned SHORT_W  = 16;
  localparam int unsigned LONG_W   = 25;
  localparam int unsigned PREFIX_W = LONG_W - SHORT_W;
  localparam logic [PREFIX_W-1:0] CR_PREFIX = 9'b1_0100_0000;

  localparam int unsigned PA_W  = 2;
  localparam int unsigned DEV_W = 3;
  localparam int unsigned MC_W  = 2;
  localparam int unsigned SW_W  = 5;
  localparam int unsigned PCT_W = 8;
  localparam int unsigned DIV_W = 7;
  localparam int unsigned N_W   = DIV_W + SW_W;

  localparam int unsigned DEV_BASE_PCT = 60;
  localparam int unsigned DEV_STEP_PCT = 10;
  localparam int unsigned MC_BASE      = 86;
  localparam logic [DEV_W-1:0] DEV_RST = 3'd4;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TX    = 2'd1,
    MODE_RX    = 2'd2,
    MODE_RX_CR = 2'd3
  } mode_e;

  typedef struct packed {
    logic [PA_W-1:0]  pa;
    logic [DEV_W-1:0] dev;
    logic             ref_sel;
    logic [MC_W-1:0]  mc;
    logic [SW_W-1:0]  sw;
  } cfg_t;

  function automatic logic [PCT_W-1:0] dev_to_pct(logic [DEV_W-1:0] code);
    int unsigned v;
    v = DEV_BASE_PCT + DEV_STEP_PCT * int'(code);
    return PCT_W'(v);
  endfunction

  function automatic logic [DIV_W-1:0] mc_to_div(logic [MC_W-1:0] code);
    int unsigned v;
    v = MC_BASE + int'(code);
    return DIV_W'(v);
  endfunction
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int unsigned N       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
  parameter int unsigned W = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         dat_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clr_i)   sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], dat_i};
  end

  assign word_o = sr_q;

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !clr_i |=> word_o == {$past(word_o[W-2:0]), $past(dat_i)}); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i && !clr_i |=> $stable(word_o)); // R5
  AST_FRAME_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> word_o == '0); // R12
endmodule

// File: rtl/cfg3w_decode.sv
module cfg3w_decode
  import cfg3w_pkg::*;
(
  input  logic [LONG_W-1:0] word_i,
  output logic              accept_o,
  output mode_e             mode_o,
  output logic              tx_fields_o,
  output cfg_t              fields_o
);
  logic       prefix_hit;
  logic [1:0] hdr;

  assign prefix_hit = (word_i[LONG_W-1:SHORT_W] == CR_PREFIX);
  assign hdr        = word_i[15:14];

  always_comb begin
    accept_o = 1'b0;
    mode_o   = MODE_OFF;
    if (prefix_hit) begin
      accept_o = (hdr == 2'b00);
      mode_o   = MODE_RX_CR;
    end else if (hdr == 2'b01) begin
      accept_o = 1'b1;
      mode_o   = word_i[8] ? MODE_TX : MODE_RX;
    end
  end

  assign tx_fields_o      = (mode_o == MODE_TX);
  assign fields_o.pa      = word_i[13:12];
  assign fields_o.dev     = word_i[11:9];
  assign fields_o.ref_sel = word_i[7];
  assign fields_o.mc      = word_i[6:5];
  assign fields_o.sw      = word_i[4:0];
endmodule

// File: rtl/cfg3w_slave.sv
module cfg3w_slave
  import cfg3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_clk_i,
  input  logic             bus_dat_i,
  input  logic             bus_en_ni,
  output logic             cfg_valid_o,
  output logic [1:0]       mode_o,
  output logic             cr_en_o,
  output logic [PA_W-1:0]  pa_lvl_o,
  output logic [DEV_W-1:0] dev_code_o,
  output logic [PCT_W-1:0] dev_pct_o,
  output logic             ref_sel_o,
  output logic [MC_W-1:0]  mc_code_o,
  output logic [DIV_W-1:0] main_div_o,
  output logic [SW_W-1:0]  swallow_o,
  output logic [N_W-1:0]   div_n_o
);
  localparam int unsigned BUS_N   = 3;
  localparam int unsigned BIT_DAT = 0;
  localparam int unsigned BIT_CLK = 1;
  localparam int unsigned BIT_EN  = 2;
  localparam logic [BUS_N-1:0] BUS_RST = 3'b100; // enable idles high

  logic [BUS_N-1:0]  bus_s;
  logic              prev_clk_q, prev_en_q;
  logic              clk_rise, en_rise, en_fall, shift_en;
  logic [LONG_W-1:0] word;
  logic              dec_accept, dec_txf, latch;
  mode_e             dec_mode, mode_q;
  cfg_t              dec_cfg, cfg_q;
  logic              cr_en_q, valid_q;

  cfg3w_sync #(.N(BUS_N), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({bus_en_ni, bus_clk_i, bus_dat_i}),
    .sync_o  (bus_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_clk_q <= 1'b0;
      prev_en_q  <= 1'b1;
    end else begin
      prev_clk_q <= bus_s[BIT_CLK];
      prev_en_q  <= bus_s[BIT_EN];
    end
  end

  assign clk_rise = bus_s[BIT_CLK] & ~prev_clk_q;
  assign en_rise  = bus_s[BIT_EN] & ~prev_en_q;
  assign en_fall  = ~bus_s[BIT_EN] & prev_en_q;
  assign shift_en = clk_rise & ~bus_s[BIT_EN];

  cfg3w_shift #(.W(LONG_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (en_fall),
    .shift_i (shift_en),
    .dat_i   (bus_s[BIT_DAT]),
    .word_o  (word)
  );

  cfg3w_decode u_decode (
    .word_i      (word),
    .accept_o    (dec_accept),
    .mode_o      (dec_mode),
    .tx_fields_o (dec_txf),
    .fields_o    (dec_cfg)
  );

  assign latch = en_rise & dec_accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      cfg_q   <= '{pa: '0, dev: DEV_RST, ref_sel: 1'b0, mc: '0, sw: '0};
      cr_en_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= latch;
      if (latch) begin
        mode_q        <= dec_mode;
        cr_en_q       <= (dec_mode == MODE_RX_CR);
        cfg_q.ref_sel <= dec_cfg.ref_sel;
        cfg_q.mc      <= dec_cfg.mc;
        cfg_q.sw      <= dec_cfg.sw;
        if (dec_txf) begin
          cfg_q.pa  <= dec_cfg.pa;
          cfg_q.dev <= dec_cfg.dev;
        end
      end
    end
  end

  assign cfg_valid_o = valid_q;
  assign mode_o      = mode_q;
  assign cr_en_o     = cr_en_q;
  assign pa_lvl_o    = cfg_q.pa;
  assign dev_code_o  = cfg_q.dev;
  assign dev_pct_o   = dev_to_pct(cfg_q.dev);
  assign ref_sel_o   = cfg_q.ref_sel;
  assign mc_code_o   = cfg_q.mc;
  assign main_div_o  = mc_to_div(cfg_q.mc);
  assign swallow_o   = cfg_q.sw;
  assign div_n_o     = {main_div_o, {SW_W{1'b0}}} + N_W'(cfg_q.sw);

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> !cfg_valid_o); // R10
  AST_HOLD_WITHOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_o |-> $stable({mode_o, cr_en_o, pa_lvl_o, dev_code_o, ref_sel_o, mc_code_o, swallow_o})); // R9
  AST_CR_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (cr_en_o == (mode_o == 2'd3))); // R7
  AST_RX_KEEPS_TX_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && mode_o != 2'd1 |-> $stable({pa_lvl_o, dev_code_o})); // R6
  AST_NO_LATCH_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_s[BIT_EN] |=> !cfg_valid_o); // R3
endmodule

// File: tb/cfg3w_slave_tb.sv
module cfg3w_slave_tb;
  typedef struct packed {
    logic [31:0] word;
    logic [5:0]  nbits;
    logic [1:0]  mode;
    logic [1:0]  pa;
    logic [2:0]  dev;
    logic        ref_sel;
    logic [1:0]  mc;
    logic [4:0]  sw;
    logic        pulse;
  } vec_t;

  // R2 R6 R7 R8 R9 R4 R12 sequence; hold rows repeat the prior expectation
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_67B6, 6'd16, 2'd1, 2'd2, 3'd3, 1'b1, 2'd1, 5'd22, 1'b1},
    '{32'h0000_7E63, 6'd16, 2'd2, 2'd2, 3'd3, 1'b0, 2'd3, 5'd3,  1'b1},
    '{32'h0140_00DF, 6'd25, 2'd3, 2'd2, 3'd3, 1'b1, 2'd2, 5'd31, 1'b1},
    '{32'h0000_5100, 6'd16, 2'd1, 2'd1, 3'd0, 1'b0, 2'd0, 5'd0,  1'b1},
    '{32'h000F_7FFF, 6'd20, 2'd1, 2'd3, 3'd7, 1'b1, 2'd3, 5'd31, 1'b1},
    '{32'h0000_8000, 6'd16, 2'd1, 2'd3, 3'd7, 1'b1, 2'd3, 5'd31, 1'b0},
    '{32'h0141_4085, 6'd25, 2'd2, 2'd3, 3'd7, 1'b1, 2'd0, 5'd5,  1'b1},
    '{32'h0140_4900, 6'd25, 2'd2, 2'd3, 3'd7, 1'b1, 2'd0, 5'd5,  1'b0},
    '{32'h0000_49DD, 6'd16, 2'd1, 2'd0, 3'd4, 1'b1, 2'd2, 5'd29, 1'b1}
  };
  localparam string VREQ [NV] = '{"R2", "R6", "R7", "R12", "R4", "R9", "R8", "R7", "R11"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, bus_dat = 1'b0, bus_en_n = 1'b1;
  logic cfg_valid, cr_en, ref_sel;
  logic [1:0] mode, pa, mc;
  logic [2:0] dev;
  logic [7:0] pct;
  logic [6:0] main_div;
  logic [4:0] sw;
  logic [11:0] div_n;

  int n_chk = 0, n_fail = 0, pulses = 0, wide = 0;
  bit done = 1'b0, prev_valid = 1'b0;

  always #2.5 clk = ~clk;

  cfg3w_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bus_clk), .bus_dat_i(bus_dat),
    .bus_en_ni(bus_en_n), .cfg_valid_o(cfg_valid), .mode_o(mode), .cr_en_o(cr_en),
    .pa_lvl_o(pa), .dev_code_o(dev), .dev_pct_o(pct), .ref_sel_o(ref_sel),
    .mc_code_o(mc), .main_div_o(main_div), .swallow_o(sw), .div_n_o(div_n)
  );

  always @(negedge clk) begin
    if (rst_n && cfg_valid) begin
      pulses++;
      if (prev_valid) wide++;
    end
    prev_valid = rst_n && cfg_valid;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int e_mode, input int e_pa, input int e_dev,
                           input int e_ref, input int e_mc, input int e_sw);
    int e_div;
    e_div = 86 + e_mc;
    check(req, "mode", int'(mode), e_mode);
    check(req, "cr_en", int'(cr_en), (e_mode == 3) ? 1 : 0);
    check(req, "pa", int'(pa), e_pa);
    check(req, "dev", int'(dev), e_dev);
    check(req, "ref", int'(ref_sel), e_ref);
    check(req, "mc", int'(mc), e_mc);
    check(req, "sw", int'(sw), e_sw);
    check("R11", "pct", int'(pct), 60 + 10 * e_dev);
    check("R11", "main_div", int'(main_div), e_div);
    check("R11", "div_n", int'(div_n), 32 * e_div + e_sw);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open(input logic [31:0] w, input int n);
    bus_en_n = 1'b0;
    cyc(6);
    for (int i = n - 1; i >= 0; i--) begin
      bus_dat = w[i];
      cyc(4);
      bus_clk = 1'b1;
      cyc(4);
      bus_clk = 1'b0;
    end
    cyc(6);
  endtask

  task automatic frame_close();
    bus_en_n = 1'b1;
    cyc(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p0;
    int s_mode, s_pa, s_dev, s_ref, s_mc, s_sw;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    check_all("R1", 0, 0, 4, 0, 0, 0);
    check("R1", "pulse", int'(cfg_valid), 0);

    for (int v = 0; v < NV; v++) begin
      s_mode = int'(mode); s_pa = int'(pa); s_dev = int'(dev);
      s_ref = int'(ref_sel); s_mc = int'(mc); s_sw = int'(sw);
      p0 = pulses;
      frame_open(VECS[v].word, int'(VECS[v].nbits));
      // R3: nothing moves before enable rises
      check_all("R3", s_mode, s_pa, s_dev, s_ref, s_mc, s_sw);
      check("R3", "pulse_in_frame", pulses - p0, 0);
      frame_close();
      check_all(VREQ[v], int'(VECS[v].mode), int'(VECS[v].pa), int'(VECS[v].dev),
                int'(VECS[v].ref_sel), int'(VECS[v].mc), int'(VECS[v].sw));
      check("R10", "pulses", pulses - p0, int'(VECS[v].pulse));
    end

    // R5: clock edges with enable high are ignored
    p0 = pulses;
    for (int i = 0; i < 30; i++) begin
      bus_dat = i[0];
      cyc(4);
      bus_clk = 1'b1;
      cyc(4);
      bus_clk = 1'b0;
    end
    cyc(10);
    check_all("R5", 1, 0, 4, 1, 2, 29);
    check("R5", "pulses", pulses - p0, 0);

    // R4: zero-clock frame decodes all zeros, which is invalid
    p0 = pulses;
    frame_open(32'h0, 0);
    frame_close();
    check_all("R4", 1, 0, 4, 1, 2, 29);
    check("R4", "pulses", pulses - p0, 0);

    // R4: 31 bits, last 16 form a receive word (D8=0, ref 0, mc 01, sw 01010)
    p0 = pulses;
    frame_open(32'h7FFF_402A, 31);
    frame_close();
    check_all("R4", 2, 0, 4, 0, 1, 10);
    check("R4", "pulses", pulses - p0, 1);

    check("R10", "wide_pulses", wide, 0);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    cyc(3);
    check_all("R1", 0, 0, 4, 0, 0, 0);
    check("R1", "pulse", int'(cfg_valid), 0);
    rst_n = 1'b1;
    cyc(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule